// File: doc/BRIEF.md
# Vectored Dual-Class Interrupt Controller

This block collects level-sensitive interrupt requests from up to 64 sources and presents them to a processor as two request lines: a normal line that is arbitrated by per-source priority under a software threshold, and a fast line for sources that software has marked as urgent. A simple 32-bit register bus, addressed by word index, gives software access to the per-source enable, class and priority settings. Software can also raise any source by itself through force bits. Read-only words report the raw inputs, the pending sets of each class and a vector word for each class that names the winning source.

Enables can be changed as a whole word, or one at a time by writing a source number to a set-by-number or a clear-by-number register. That way a driver can mask or unmask one line without a read-modify-write. Pending state is not latched: it follows the input levels, so a source that drops its line stops requesting with no acknowledge write. The two request outputs are registered.

Top module: `dual_class_intc`

## Requirements
- R1: After reset the control word (index 0) reads 0, the threshold word (index 1) reads 0x1F, and the enable (indices 4/5), class (6/7), force (20/21) and priority (8..15) words read 0. Both vector words (indices 16 and 17) read 0xFFFF0000 and both request outputs are low.
- R2: Writing a value n below 64 to index 2 sets enable bit n, and writing it to index 3 clears enable bit n. No other enable bit changes. A value of 64 or more written to either index changes nothing, and both indices read as 0.
- R3: The effective request of source n is (src_i[n] OR force bit n) AND enable bit n. Normal pending (indices 22 high, 23 low) is the effective request AND NOT class bit n. Fast pending (indices 24 high, 25 low) is the effective request AND class bit n. In every high/low word pair, the high word holds sources 32..63 and the low word holds sources 0..31, with source n at bit n mod 32.
- R4: Pending is level-sensitive. When a source line falls and its force bit is 0, its pending bit reads 0 again with no register write.
- R5: Source n has a 4-bit priority at bits 4*(n mod 8)+3 .. 4*(n mod 8) of priority register x = n/8. That register is at word index 15-x, so sources 56..63 are at index 8 and sources 0..7 are at index 15. The registers can be read back.
- R6: The normal vector word (index 16) holds the eligible normal pending source with the highest priority in bits [21:16] and its priority in bits [3:0]; all other bits are 0. On equal priority the higher source number wins. With no eligible source it reads 0xFFFF0000.
- R7: If threshold bit 4 is 1, every normal pending source is eligible. Otherwise a source is eligible only if its priority is strictly greater than threshold bits [3:0].
- R8: The fast vector word (index 17) holds the highest-numbered fast pending source in bits [21:16], with all other bits 0. With no fast pending source it reads 0xFFFF0000.
- R9: irq_norm_o is high exactly one clock after the normal vector is valid, and irq_fast_o is high exactly one clock after any fast pending bit is set.
- R10: Indices 18 (high) and 19 (low) read the raw src_i levels. The force words at indices 20 and 21 read back what was written.
- R11: The control word, the enable words (4 high, 5 low) and the class words (6 high, 7 low) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_word | input | 5 | Register word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| src_i | input | NUM_SRC | Level-sensitive source requests |
| irq_norm_o | output | 1 | Registered normal-class request |
| irq_fast_o | output | 1 | Registered fast-class request |

## Verification
The bench uses the default NUM_SRC of 64, so every word of the register map holds real sources. It can therefore walk each source singly through the set/clear-by-number path, the pending and raw words, and the priority nibble packed in reversed register order. Full sweeps of all 32 threshold values and dozens of computed multi-source patterns bring the tie rule and the strict-greater masking edge into play against a bench-side model of the arbitration. The one-cycle output latency is checked at a clock edge for both classes, on the rising and on the falling edge of a request.

// File: rtl/dcic_pkg.sv
package dcic_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned WIDX_W = 5;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned PRIO_PER_WORD = BUS_W / PRIO_W;
  localparam int unsigned PRIO_WORDS = 8;
  localparam int unsigned THR_W = PRIO_W + 1;

  localparam logic [WIDX_W-1:0] W_CTRL   = 5'd0;
  localparam logic [WIDX_W-1:0] W_THR    = 5'd1;
  localparam logic [WIDX_W-1:0] W_ENNUM  = 5'd2;
  localparam logic [WIDX_W-1:0] W_DISNUM = 5'd3;
  localparam logic [WIDX_W-1:0] W_ENH    = 5'd4;
  localparam logic [WIDX_W-1:0] W_ENL    = 5'd5;
  localparam logic [WIDX_W-1:0] W_TYPH   = 5'd6;
  localparam logic [WIDX_W-1:0] W_TYPL   = 5'd7;
  localparam logic [WIDX_W-1:0] W_PRI0   = 5'd8;
  localparam logic [WIDX_W-1:0] W_NVEC   = 5'd16;
  localparam logic [WIDX_W-1:0] W_FVEC   = 5'd17;
  localparam logic [WIDX_W-1:0] W_SRCH   = 5'd18;
  localparam logic [WIDX_W-1:0] W_SRCL   = 5'd19;
  localparam logic [WIDX_W-1:0] W_FRCH   = 5'd20;
  localparam logic [WIDX_W-1:0] W_FRCL   = 5'd21;
  localparam logic [WIDX_W-1:0] W_NPH    = 5'd22;
  localparam logic [WIDX_W-1:0] W_NPL    = 5'd23;
  localparam logic [WIDX_W-1:0] W_FPH    = 5'd24;
  localparam logic [WIDX_W-1:0] W_FPL    = 5'd25;

  localparam logic [THR_W-1:0] THR_RESET = 5'h1F;
  localparam logic [15:0] VEC_NONE = 16'hFFFF;
endpackage

// File: rtl/dcic_regs.sv
module dcic_regs
  import dcic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [WIDX_W-1:0]                wr_idx,
  input  logic [BUS_W-1:0]                 wr_data,
  output logic [BUS_W-1:0]                 ctrl_q,
  output logic [THR_W-1:0]                 thr_q,
  output logic [NUM_SRC-1:0]               en_q,
  output logic [NUM_SRC-1:0]               typ_q,
  output logic [NUM_SRC-1:0]               frc_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q
);
  logic [BUS_W-1:0]               ctrl_d;
  logic [THR_W-1:0]               thr_d;
  logic [NUM_SRC-1:0]             en_d, typ_d, frc_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_d;
  logic [63:0]                    en_w, typ_w, frc_w;
  logic                           num_ok;

  assign num_ok = (wr_data < 32'(NUM_SRC));

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    thr_d  = thr_q;
    prio_d = prio_q;
    en_w   = 64'(en_q);
    typ_w  = 64'(typ_q);
    frc_w  = 64'(frc_q);
    if (wr_en) begin
      unique case (wr_idx)
        W_CTRL:   ctrl_d = wr_data;
        W_THR:    thr_d  = wr_data[THR_W-1:0];
        W_ENNUM:  if (num_ok) en_w[wr_data[IDX_W-1:0]] = 1'b1;
        W_DISNUM: if (num_ok) en_w[wr_data[IDX_W-1:0]] = 1'b0;
        W_ENH:    en_w[63:32]  = wr_data;
        W_ENL:    en_w[31:0]   = wr_data;
        W_TYPH:   typ_w[63:32] = wr_data;
        W_TYPL:   typ_w[31:0]  = wr_data;
        W_FRCH:   frc_w[63:32] = wr_data;
        W_FRCL:   frc_w[31:0]  = wr_data;
        default: begin
          for (int w = 0; w < int'(PRIO_WORDS); w++) begin
            if (wr_idx == W_PRI0 + WIDX_W'(w)) begin
              for (int k = 0; k < int'(PRIO_PER_WORD); k++) begin
                if (((int'(PRIO_WORDS) - 1 - w) * int'(PRIO_PER_WORD) + k) < int'(NUM_SRC))
                  prio_d[(int'(PRIO_WORDS) - 1 - w) * int'(PRIO_PER_WORD) + k] =
                    wr_data[PRIO_W*k +: PRIO_W];
              end
            end
          end
        end
      endcase
    end
    en_d  = en_w[NUM_SRC-1:0];
    typ_d = typ_w[NUM_SRC-1:0];
    frc_d = frc_w[NUM_SRC-1:0];
  end

  // registers, clock-enabled by a bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= THR_RESET;
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
      en_q   <= en_d;
      typ_q  <= typ_d;
      frc_q  <= frc_d;
      prio_q <= prio_d;
    end
  end

  // R2: set-by-number touches exactly one bit
  p_ennum_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == W_ENNUM && num_ok) |=>
      (en_q == ($past(en_q) | (NUM_SRC'(1) << $past(wr_data[IDX_W-1:0])))));

  // R2: clear-by-number touches exactly one bit
  p_disnum_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == W_DISNUM && num_ok) |=>
      (en_q == ($past(en_q) & ~(NUM_SRC'(1) << $past(wr_data[IDX_W-1:0])))));

  // R2: out-of-range numbers leave the enables alone
  p_num_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == W_ENNUM || wr_idx == W_DISNUM) && !num_ok) |=> $stable(en_q));
endmodule

// File: rtl/dcic_norm_arb.sv
module dcic_norm_arb
  import dcic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned LEAVES = 1 << IDX_W,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [THR_W-1:0]               thr,
  output logic                           vld,
  output logic [IDX_W-1:0]               idx,
  output logic [PRIO_W-1:0]              pri
);
  typedef struct packed {
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] pri;
  } node_t;

  node_t heap [NODES];

  // right child holds the higher source numbers, so it wins ties
  function automatic node_t pick(node_t lo, node_t hi);
    if (hi.vld && (!lo.vld || hi.pri >= lo.pri)) return hi;
    return lo;
  endfunction

  always_comb begin
    for (int g = 0; g < int'(LEAVES); g++) begin
      heap[int'(LEAVES) - 1 + g] = '0;
      if (g < int'(NUM_SRC)) begin
        heap[int'(LEAVES) - 1 + g].vld =
          pend[g] && (thr[THR_W-1] || (prio[g] > thr[PRIO_W-1:0]));
        heap[int'(LEAVES) - 1 + g].idx = IDX_W'(g);
        heap[int'(LEAVES) - 1 + g].pri = prio[g];
      end
    end
    for (int i = int'(LEAVES) - 2; i >= 0; i--) begin
      heap[i] = pick(heap[2*i+1], heap[2*i+2]);
    end
  end

  assign vld = heap[0].vld;
  assign idx = heap[0].idx;
  assign pri = heap[0].pri;

  // R6: winner is pending and reported with its own priority
  p_nvec_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pend[idx] && pri == prio[idx]));

  // R7: below-threshold sources never win
  p_nvec_above_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !thr[THR_W-1]) |-> (pri > thr[PRIO_W-1:0]));

  // R7: unmasked, any pending source produces a winner
  p_nvec_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr[THR_W-1] && (|pend)) |-> vld);
endmodule

// File: rtl/dcic_fast_enc.sv
module dcic_fast_enc #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  output logic               vld,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int s = 0; s < int'(NUM_SRC); s++) begin
      if (pend[s]) begin
        vld = 1'b1;
        idx = IDX_W'(s);
      end
    end
  end

  // R8: reported source is pending and nothing above it is
  p_fvec_highest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((pend >> idx) == NUM_SRC'(1)));

  p_fvec_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (pend == '0));
endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import dcic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [4:0]         bus_word,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_norm_o,
  output logic               irq_fast_o
);
  logic [BUS_W-1:0]               ctrl_q;
  logic [THR_W-1:0]               thr_q;
  logic [NUM_SRC-1:0]             en_q, typ_q, frc_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             eff_req, norm_pend, fast_pend;
  logic                           n_vld, f_vld;
  logic [IDX_W-1:0]               n_idx, f_idx;
  logic [PRIO_W-1:0]              n_pri;
  logic [31:0]                    nvec_w, fvec_w, prio_rd;
  logic [63:0]                    en_x, typ_x, frc_x, src_x, np_x, fp_x;
  logic                           irq_norm_d, irq_fast_d, irq_norm_q, irq_fast_q;

  dcic_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_sel && bus_we),
    .wr_idx  (bus_word),
    .wr_data (bus_wdata),
    .ctrl_q  (ctrl_q),
    .thr_q   (thr_q),
    .en_q    (en_q),
    .typ_q   (typ_q),
    .frc_q   (frc_q),
    .prio_q  (prio_q)
  );

  assign eff_req   = (src_i | frc_q) & en_q;
  assign norm_pend = eff_req & ~typ_q;
  assign fast_pend = eff_req & typ_q;

  dcic_norm_arb #(.NUM_SRC(NUM_SRC)) narb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (norm_pend),
    .prio  (prio_q),
    .thr   (thr_q),
    .vld   (n_vld),
    .idx   (n_idx),
    .pri   (n_pri)
  );

  dcic_fast_enc #(.NUM_SRC(NUM_SRC)) fenc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (fast_pend),
    .vld   (f_vld),
    .idx   (f_idx)
  );

  assign nvec_w = n_vld ? {{(16-IDX_W){1'b0}}, n_idx, {(16-PRIO_W){1'b0}}, n_pri}
                        : {VEC_NONE, 16'h0};
  assign fvec_w = f_vld ? {{(16-IDX_W){1'b0}}, f_idx, 16'h0}
                        : {VEC_NONE, 16'h0};

  assign en_x  = 64'(en_q);
  assign typ_x = 64'(typ_q);
  assign frc_x = 64'(frc_q);
  assign src_x = 64'(src_i);
  assign np_x  = 64'(norm_pend);
  assign fp_x  = 64'(fast_pend);

  // priority word readback, reversed register order
  always_comb begin
    prio_rd = '0;
    for (int w = 0; w < int'(PRIO_WORDS); w++) begin
      if (bus_word == W_PRI0 + 5'(w)) begin
        for (int k = 0; k < int'(PRIO_PER_WORD); k++) begin
          if (((int'(PRIO_WORDS) - 1 - w) * int'(PRIO_PER_WORD) + k) < int'(NUM_SRC))
            prio_rd[PRIO_W*k +: PRIO_W] =
              prio_q[(int'(PRIO_WORDS) - 1 - w) * int'(PRIO_PER_WORD) + k];
        end
      end
    end
  end

  always_comb begin
    unique case (bus_word)
      W_CTRL:  bus_rdata = ctrl_q;
      W_THR:   bus_rdata = 32'(thr_q);
      W_ENH:   bus_rdata = en_x[63:32];
      W_ENL:   bus_rdata = en_x[31:0];
      W_TYPH:  bus_rdata = typ_x[63:32];
      W_TYPL:  bus_rdata = typ_x[31:0];
      W_NVEC:  bus_rdata = nvec_w;
      W_FVEC:  bus_rdata = fvec_w;
      W_SRCH:  bus_rdata = src_x[63:32];
      W_SRCL:  bus_rdata = src_x[31:0];
      W_FRCH:  bus_rdata = frc_x[63:32];
      W_FRCL:  bus_rdata = frc_x[31:0];
      W_NPH:   bus_rdata = np_x[63:32];
      W_NPL:   bus_rdata = np_x[31:0];
      W_FPH:   bus_rdata = fp_x[63:32];
      W_FPL:   bus_rdata = fp_x[31:0];
      default: bus_rdata = prio_rd;
    endcase
  end

  // output stage
  assign irq_norm_d = n_vld;
  assign irq_fast_d = |fast_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_q <= 1'b0;
      irq_fast_q <= 1'b0;
    end else begin
      irq_norm_q <= irq_norm_d;
      irq_fast_q <= irq_fast_d;
    end
  end

  assign irq_norm_o = irq_norm_q;
  assign irq_fast_o = irq_fast_q;

  // R9: outputs lag their conditions by one clock
  p_norm_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_norm_o == $past(fvec_w[31:16] != VEC_NONE ? n_vld : n_vld)));

  p_fast_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_fast_o == $past(fvec_w[31:16] != VEC_NONE)));

  // R3: a source is never pending in both classes
  p_class_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_w[31:16] != VEC_NONE && fvec_w[31:16] != VEC_NONE) |-> (n_idx != f_idx));
endmodule

// File: tb/dual_class_intc_tb.sv
module dual_class_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '0;
  logic        irq_norm_o, irq_fast_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_en = '0, m_typ = '0, m_frc = '0;
  logic [3:0]  bprio [64];
  int          m_thr = 31;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_class_intc #(.NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = 5'(w); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    bus_word = 5'(w);
    #1;
    d = bus_rdata;
  endtask

  task automatic rd64(input int hi, input int lo, output logic [63:0] d);
    logic [31:0] h, l;
    rd(hi, h);
    rd(lo, l);
    d = {h, l};
  endtask

  function automatic logic [31:0] exp_nvec(input logic [63:0] p, input int thr);
    int best = -1;
    int bp = 0;
    for (int n = 0; n < 64; n++) begin
      if (p[n] && (thr >= 16 || int'(bprio[n]) > thr) && (best < 0 || int'(bprio[n]) >= bp)) begin
        best = n;
        bp = int'(bprio[n]);
      end
    end
    if (best < 0) return 32'hFFFF0000;
    return (32'(best) << 16) | 32'(bp);
  endfunction

  function automatic logic [31:0] exp_fvec(input logic [63:0] p);
    int best = -1;
    for (int n = 0; n < 64; n++) if (p[n]) best = n;
    if (best < 0) return 32'hFFFF0000;
    return 32'(best) << 16;
  endfunction

  function automatic logic [63:0] pat(input int k);
    logic [31:0] a, b, c;
    a = 32'(k) * 32'h9E3779B1;
    b = (32'(k) * 32'h85EBCA77) ^ 32'h5BD1E995;
    c = (32'(k) * 32'hC2B2AE35) ^ 32'h27D4EB2F;
    return {a & b, b & c};
  endfunction

  task automatic prog_prio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < 8; k++) w[4*k +: 4] = bprio[x*8+k];
      wr(8 + 7 - x, w);
    end
  endtask

  task automatic chk_pend(input string tag);
    logic [63:0] g, eff;
    eff = (src | m_frc) & m_en;
    rd64(22, 23, g); chk({tag, " normal pending"}, g, eff & ~m_typ);
    rd64(24, 25, g); chk({tag, " fast pending"}, g, eff & m_typ);
  endtask

  task automatic chk_vec(input string tag);
    logic [31:0] g;
    logic [63:0] eff;
    eff = (src | m_frc) & m_en;
    rd(16, g); chk({tag, " normal vector"}, 64'(g), 64'(exp_nvec(eff & ~m_typ, m_thr)));
    rd(17, g); chk({tag, " fast vector"}, 64'(g), 64'(exp_fvec(eff & m_typ)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] q;
    for (int n = 0; n < 64; n++) bprio[n] = 4'((n * 7 + 3) % 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, d);  chk("R1 control", 64'(d), 64'h0);
    rd(1, d);  chk("R1 threshold", 64'(d), 64'h1F);
    rd64(4, 5, q);   chk("R1 enable", q, 64'h0);
    rd64(6, 7, q);   chk("R1 class", q, 64'h0);
    rd64(20, 21, q); chk("R1 force", q, 64'h0);
    for (int w = 8; w < 16; w++) begin rd(w, d); chk("R1 priority word", 64'(d), 64'h0); end
    rd(16, d); chk("R1 normal vector", 64'(d), 64'hFFFF0000);
    rd(17, d); chk("R1 fast vector", 64'(d), 64'hFFFF0000);
    chk("R1 outputs", {62'h0, irq_norm_o, irq_fast_o}, 64'h0);

    // R2 set/clear by number
    for (int n = 0; n < 64; n++) begin
      wr(2, 32'(n)); m_en[n] = 1'b1;
      rd64(4, 5, q); chk("R2 set by number", q, m_en);
    end
    wr(3, 32'd64);          rd64(4, 5, q); chk("R2 clear of 64 ignored", q, m_en);
    wr(3, 32'h4000_0001);   rd64(4, 5, q); chk("R2 large clear ignored", q, m_en);
    for (int n = 0; n < 64; n += 2) begin
      wr(3, 32'(n)); m_en[n] = 1'b0;
      rd64(4, 5, q); chk("R2 clear by number", q, m_en);
    end
    wr(2, 32'd64);          rd64(4, 5, q); chk("R2 set of 64 ignored", q, m_en);
    wr(2, 32'h8000_0002);   rd64(4, 5, q); chk("R2 large set ignored", q, m_en);
    rd(2, d); chk("R2 set word reads 0", 64'(d), 64'h0);
    rd(3, d); chk("R2 clear word reads 0", 64'(d), 64'h0);

    // R11 direct readback
    wr(0, 32'hA5C3_1E0F); rd(0, d); chk("R11 control", 64'(d), 64'hA5C31E0F);
    m_en = 64'h1234_5678_9ABC_DEF0; wr(4, m_en[63:32]); wr(5, m_en[31:0]);
    rd64(4, 5, q); chk("R11 enable words", q, m_en);
    m_typ = 64'h0F0F_F0F0_3333_CCCC; wr(6, m_typ[63:32]); wr(7, m_typ[31:0]);
    rd64(6, 7, q); chk("R11 class words", q, m_typ);

    // R3 / R10 single-source sweep
    m_en = '1; wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    m_typ = 64'hF0F0_0FF0_3C3C_A5A5; wr(6, m_typ[63:32]); wr(7, m_typ[31:0]);
    for (int n = 0; n < 64; n++) begin
      src = 64'h1 << n;
      rd64(18, 19, q); chk("R10 raw source", q, src);
      chk_pend("R3 single source");
    end
    m_en = 64'h5555_AAAA_0F0F_F00F; wr(4, m_en[63:32]); wr(5, m_en[31:0]);
    for (int k = 1; k < 13; k++) begin
      src = pat(k);
      chk_pend("R3 pattern");
    end
    src = '0;
    m_frc = 64'h8001_0000_0000_C002; wr(20, m_frc[63:32]); wr(21, m_frc[31:0]);
    rd64(20, 21, q); chk("R10 force readback", q, m_frc);
    chk_pend("R3 forced");

    // R4 level-sensitive clear
    m_frc = '0; wr(20, 0); wr(21, 0);
    m_en = '1; wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    src = 64'h0000_0400_0001_0400;
    chk_pend("R4 raised");
    src = '0;
    rd64(22, 23, q); chk("R4 normal pending drops", q, 64'h0);
    rd64(24, 25, q); chk("R4 fast pending drops", q, 64'h0);

    // R5 priority layout
    prog_prio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < 8; k++) w[4*k +: 4] = bprio[x*8+k];
      rd(15 - x, d); chk("R5 priority readback", 64'(d), 64'(w));
    end
    m_typ = '0; wr(6, 0); wr(7, 0);
    for (int n = 0; n < 64; n++) begin
      src = 64'h1 << n;
      rd(16, d); chk("R5 priority of single source", 64'(d), (64'(n) << 16) | 64'(bprio[n]));
    end

    // R6 arbitration over patterns
    for (int k = 1; k < 41; k++) begin
      src = pat(k);
      chk_vec("R6 pattern");
    end
    for (int w = 8; w < 16; w++) wr(w, 32'h5555_5555);
    for (int n = 0; n < 64; n++) bprio[n] = 4'h5;
    src = (64'h1 << 3) | (64'h1 << 40);
    rd(16, d); chk("R6 tie to higher number", 64'(d), 64'h0028_0005);
    src = 64'h1 << 3;
    rd(16, d); chk("R6 lone source", 64'(d), 64'h0003_0005);
    for (int n = 0; n < 64; n++) bprio[n] = 4'((n * 7 + 3) % 16);
    prog_prio();

    // R7 threshold sweep
    src = pat(7) | pat(11);
    for (int m = 0; m < 32; m++) begin
      wr(1, 32'(m)); m_thr = m;
      chk_vec("R7 threshold");
    end
    wr(1, 32'h1F); m_thr = 31;

    // R8 fast class
    m_typ = 64'hC3A5_5A3C_9966_0FF0; wr(6, m_typ[63:32]); wr(7, m_typ[31:0]);
    for (int k = 1; k < 25; k++) begin
      src = pat(k + 50);
      chk_vec("R8 mixed");
    end
    src = 64'h0;
    rd(17, d); chk("R8 no fast source", 64'(d), 64'hFFFF0000);

    // R9 output latency
    m_typ = 64'h1 << 20; wr(6, 0); wr(7, m_typ[31:0]);
    @(negedge clk); src = 64'h1 << 5; #1;
    chk("R9 normal not yet", 64'(irq_norm_o), 64'h0);
    @(posedge clk); #1;
    chk("R9 normal after one clock", 64'(irq_norm_o), 64'h1);
    chk("R9 fast idle", 64'(irq_fast_o), 64'h0);
    @(negedge clk); src = 64'h1 << 20; #1;
    chk("R9 normal still held", 64'(irq_norm_o), 64'h1);
    chk("R9 fast not yet", 64'(irq_fast_o), 64'h0);
    @(posedge clk); #1;
    chk("R9 fast after one clock", 64'(irq_fast_o), 64'h1);
    chk("R9 normal released", 64'(irq_norm_o), 64'h0);
    @(negedge clk); src = '0; #1;
    chk("R9 fast held before edge", 64'(irq_fast_o), 64'h1);
    @(posedge clk); #1;
    chk("R9 fast released", 64'(irq_fast_o), 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule